// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and date as packed BCD fields: seconds, minutes, hours, weekday, day of month, month and a two-digit year that stands for 2000 through 2099. It is driven by a prescaled tick strobe, usually 32768 Hz. An internal sub-second counter turns those ticks into a half-second phase bit and a once-per-second step. The step ripples through the fields in calendar order. Month lengths follow the calendar, and February gets a 29th day whenever the two-digit year is a multiple of four.

Software sets the time through a single-cycle write port. The port carries a field code and one BCD byte. A write lands at the clock edge where its strobe is sampled, and counting goes on from the new value. Writing the seconds or minutes field clears the sub-second state, which lets software align the second boundary to a chosen instant.

A sync flag rises a configurable number of ticks before each seconds step. While the flag is low, the fields can be read or written with no carry about to change them. When the enable input is low, ticks are ignored and every field holds its value.

Top module: `cal_time_counter`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, weekday 06, day 01, month 01 and year 00, with half_o and sync_o low.
- R2: With en_i high, seconds advance by one every TICKS_PER_SEC cycles in which tick_i is high. half_o is low for the first TICKS_PER_SEC/2 counted ticks of each second and high for the rest.
- R3: Seconds wrap from 59 to 00 and advance minutes. Minutes wrap from 59 to 00 and advance hours. Hours wrap from 23 to 00, and that same step advances both the weekday (06 wraps to 00) and the day.
- R4: The day wraps to 01 and advances the month after day 30 in months 04, 06, 09 and 11, and after day 31 in every month other than February. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R5: February ends after day 29 when the BCD year is a multiple of four (including 00), and after day 28 otherwise.
- R6: A write with wr_valid_i high stores wr_data_i into the field selected by wr_field_i, and the new value is visible on the output after that clock edge. The field codes are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month and 6 year. Code 7 changes nothing.
- R7: A write to seconds or minutes clears the sub-second count and half_o, and it cancels any seconds step due in that cycle. The next seconds step then comes after a full TICKS_PER_SEC counted ticks.
- R8: A write to any other field does not stop counting. If that write falls in the cycle of a carry into the written field, the written value wins and all other fields still step.
- R9: sync_o is high exactly during the last SYNC_LEAD counted ticks before each seconds step, and low otherwise.
- R10: While en_i is low, or tick_i is low, the sub-second state and all fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Counting enable |
| tick_i | input | 1 | Prescaled tick strobe, one cycle per tick |
| wr_valid_i | input | 1 | Field write strobe |
| wr_field_i | input | 3 | Field code of the write |
| wr_data_i | input | 8 | BCD value to write |
| sec_o | output | 8 | Seconds, BCD 00-59 |
| min_o | output | 8 | Minutes, BCD 00-59 |
| hour_o | output | 8 | Hours, BCD 00-23 |
| wday_o | output | 8 | Weekday, 00-06 |
| day_o | output | 8 | Day of month, BCD 01-31 |
| month_o | output | 8 | Month, BCD 01-12 |
| year_o | output | 8 | Year within the century, BCD 00-99 |
| half_o | output | 1 | Half-second phase |
| sync_o | output | 1 | High when a seconds step is imminent |

## Verification
The bench builds the block with TICKS_PER_SEC = 8 and SYNC_LEAD = 2, so one second takes eight enabled ticks and the sync window covers the last two of them. With those values, the sub-second phase, the sync window and the write-time prescaler clear can each be checked tick by tick. Calendar boundaries such as the end of a 30-day month, a leap or common February and the century wrap are reached by writing a time one second before each one.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int FW         = 8;
  localparam int NUM_FIELDS = 7;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_WDAY  = 3'd3,
    FLD_DAY   = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6
  } cal_field_e;

  // Two-digit BCD increment, no wrap handling.
  function automatic logic [FW-1:0] bcd_inc(input logic [FW-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Multiple of four on a BCD year: even tens with units 0/4/8, odd tens with 2/6.
  function automatic logic is_leap(input logic [FW-1:0] y);
    case (y[3:0])
      4'd0, 4'd4, 4'd8: return ~y[4];
      4'd2, 4'd6:       return y[4];
      default:          return 1'b0;
    endcase
  endfunction

  function automatic logic [FW-1:0] month_days(input logic [FW-1:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [FW-1:0] field_reset(input int idx);
    case (idx)
      3:       return 8'h06;
      4, 5:    return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SYNC_LEAD     = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic clr_i,
  output logic half_o,
  output logic sync_o,
  output logic sec_pulse_o
);

  localparam int HALF = TICKS_PER_SEC / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST       = CW'(HALF - 1);
  localparam logic [CW-1:0] SYNC_START = CW'(HALF - SYNC_LEAD);

  logic [CW-1:0] sub_q, sub_d;
  logic          half_q, half_d;
  logic          adv;

  assign adv = en_i && tick_i && !clr_i;

  always_comb begin
    sub_d  = sub_q;
    half_d = half_q;
    if (clr_i) begin
      sub_d  = '0;
      half_d = 1'b0;
    end else if (adv) begin
      if (sub_q == LAST) begin
        sub_d  = '0;
        half_d = ~half_q;
      end else begin
        sub_d = sub_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q  <= '0;
      half_q <= 1'b0;
    end else begin
      sub_q  <= sub_d;
      half_q <= half_d;
    end
  end

  assign sec_pulse_o = adv && half_q && (sub_q == LAST);
  assign sync_o      = half_q && (sub_q >= SYNC_START);
  assign half_o      = half_q;

endmodule

// File: rtl/cal_field.sv
module cal_field
  import cal_pkg::*;
#(
  parameter logic [FW-1:0] RESET_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          at_max_i,
  input  logic [FW-1:0] wrap_to_i,
  input  logic          wr_i,
  input  logic [FW-1:0] wr_data_i,
  output logic [FW-1:0] value_o
);

  logic [FW-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (wr_i)        val_d = wr_data_i;
    else if (step_i) val_d = at_max_i ? wrap_to_i : bcd_inc(val_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= RESET_VAL;
    else         val_q <= val_d;
  end

  assign value_o = val_q;

endmodule

// File: rtl/cal_time_counter.sv
module cal_time_counter
  import cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SYNC_LEAD     = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          wr_valid_i,
  input  logic [2:0]    wr_field_i,
  input  logic [FW-1:0] wr_data_i,
  output logic [FW-1:0] sec_o,
  output logic [FW-1:0] min_o,
  output logic [FW-1:0] hour_o,
  output logic [FW-1:0] wday_o,
  output logic [FW-1:0] day_o,
  output logic [FW-1:0] month_o,
  output logic [FW-1:0] year_o,
  output logic          half_o,
  output logic          sync_o
);

  logic rst_n;
  logic minsec_wr;
  logic sec_pulse;

  logic [FW-1:0]         val     [NUM_FIELDS];
  logic [FW-1:0]         wrap_at [NUM_FIELDS];
  logic [FW-1:0]         wrap_to [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] at_max;
  logic [NUM_FIELDS-1:0] step;

  cal_rst_sync i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  assign minsec_wr = wr_valid_i &&
                     ((wr_field_i == 3'(FLD_SEC)) || (wr_field_i == 3'(FLD_MIN)));

  cal_prescaler #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .SYNC_LEAD     (SYNC_LEAD)
  ) i_prescaler (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .en_i        (en_i),
    .tick_i      (tick_i),
    .clr_i       (minsec_wr),
    .half_o      (half_o),
    .sync_o      (sync_o),
    .sec_pulse_o (sec_pulse)
  );

  always_comb begin
    wrap_at[FLD_SEC]   = 8'h59;
    wrap_at[FLD_MIN]   = 8'h59;
    wrap_at[FLD_HOUR]  = 8'h23;
    wrap_at[FLD_WDAY]  = 8'h06;
    wrap_at[FLD_DAY]   = month_days(val[FLD_MONTH], is_leap(val[FLD_YEAR]));
    wrap_at[FLD_MONTH] = 8'h12;
    wrap_at[FLD_YEAR]  = 8'h99;
    wrap_to[FLD_SEC]   = 8'h00;
    wrap_to[FLD_MIN]   = 8'h00;
    wrap_to[FLD_HOUR]  = 8'h00;
    wrap_to[FLD_WDAY]  = 8'h00;
    wrap_to[FLD_DAY]   = 8'h01;
    wrap_to[FLD_MONTH] = 8'h01;
    wrap_to[FLD_YEAR]  = 8'h00;
  end

  // Carry chain: the hour wrap feeds both weekday and day.
  always_comb begin
    step[FLD_SEC]   = sec_pulse;
    step[FLD_MIN]   = sec_pulse & at_max[FLD_SEC];
    step[FLD_HOUR]  = sec_pulse & at_max[FLD_SEC] & at_max[FLD_MIN];
    step[FLD_WDAY]  = sec_pulse & at_max[FLD_SEC] & at_max[FLD_MIN] & at_max[FLD_HOUR];
    step[FLD_DAY]   = step[FLD_WDAY];
    step[FLD_MONTH] = step[FLD_DAY] & at_max[FLD_DAY];
    step[FLD_YEAR]  = step[FLD_MONTH] & at_max[FLD_MONTH];
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign at_max[i] = (val[i] == wrap_at[i]);

    cal_field #(
      .RESET_VAL (field_reset(i))
    ) i_field (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .step_i    (step[i]),
      .at_max_i  (at_max[i]),
      .wrap_to_i (wrap_to[i]),
      .wr_i      (wr_valid_i && (wr_field_i == 3'(i))),
      .wr_data_i (wr_data_i),
      .value_o   (val[i])
    );
  end

  assign sec_o   = val[FLD_SEC];
  assign min_o   = val[FLD_MIN];
  assign hour_o  = val[FLD_HOUR];
  assign wday_o  = val[FLD_WDAY];
  assign day_o   = val[FLD_DAY];
  assign month_o = val[FLD_MONTH];
  assign year_o  = val[FLD_YEAR];

endmodule

// File: rtl/cal_time_counter_chk.sv
module cal_time_counter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       tick_i,
  input logic       wr_valid_i,
  input logic [2:0] wr_field_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] day_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic       half_o,
  input logic       sync_o,
  input logic       sec_pulse
);

  a_r10_hold_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_valid_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
                                $stable(day_o) && $stable(month_o) && $stable(year_o) &&
                                $stable(half_o)));

  a_r2_sec_only_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_valid_i && !(en_i && tick_i)) |=> $stable(sec_o));

  a_r3_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse && !wr_valid_i && sec_o == 8'h59) |=> (sec_o == 8'h00));

  a_r4_century_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse && !wr_valid_i && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23 &&
     day_o == 8'h31 && month_o == 8'h12 && year_o == 8'h99)
    |=> (year_o == 8'h00 && month_o == 8'h01 && day_o == 8'h01));

  a_r7_minsec_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && (wr_field_i == 3'd0 || wr_field_i == 3'd1)) |=> (!half_o && !sync_o));

  a_r9_sync_before_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse |-> sync_o);

endmodule

bind cal_time_counter cal_time_counter_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .tick_i     (tick_i),
  .wr_valid_i (wr_valid_i),
  .wr_field_i (wr_field_i),
  .sec_o      (sec_o),
  .min_o      (min_o),
  .hour_o     (hour_o),
  .day_o      (day_o),
  .month_o    (month_o),
  .year_o     (year_o),
  .half_o     (half_o),
  .sync_o     (sync_o),
  .sec_pulse  (sec_pulse)
);

// File: tb/test_cal_time_counter.sv
module test_cal_time_counter;

  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 8;
  localparam int LEAD       = 2;
  localparam int HALF       = TPS / 2;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       en_i, tick_i, wr_valid_i;
  logic [2:0] wr_field_i;
  logic [7:0] wr_data_i;
  logic [7:0] sec_o, min_o, hour_o, wday_o, day_o, month_o, year_o;
  logic       half_o, sync_o;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;

  // reference state, binary
  int m_s, m_mi, m_h, m_wd, m_d, m_mo, m_y, m_sub, m_half;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cal_time_counter #(.TICKS_PER_SEC(TPS), .SYNC_LEAD(LEAD)) i_cal_time_counter (
    .clk_i, .rst_ni, .en_i, .tick_i, .wr_valid_i, .wr_field_i, .wr_data_i,
    .sec_o, .min_o, .hour_o, .wday_o, .day_o, .month_o, .year_o, .half_o, .sync_o
  );

  function automatic logic [7:0] to_bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every clock
  always @(posedge clk_i) begin
    bit pulse;
    pulse = 1'b0;
    if (!rst_ni) begin
      m_s = 0; m_mi = 0; m_h = 0; m_wd = 6; m_d = 1; m_mo = 1; m_y = 0;
      m_sub = 0; m_half = 0;
    end else begin
      if (wr_valid_i && (wr_field_i == 3'd0 || wr_field_i == 3'd1)) begin
        m_sub = 0; m_half = 0;
      end else if (en_i && tick_i) begin
        if (m_sub == HALF - 1) begin
          m_sub = 0;
          pulse = (m_half == 1);
          m_half = 1 - m_half;
        end else m_sub++;
      end
      if (pulse) begin
        m_s++;
        if (m_s == 60) begin
          m_s = 0; m_mi++;
          if (m_mi == 60) begin
            m_mi = 0; m_h++;
            if (m_h == 24) begin
              m_h = 0;
              m_wd = (m_wd == 6) ? 0 : m_wd + 1;
              m_d++;
              if (m_d > mdays(m_mo, m_y)) begin
                m_d = 1; m_mo++;
                if (m_mo > 12) begin
                  m_mo = 1;
                  m_y = (m_y + 1) % 100;
                end
              end
            end
          end
        end
      end
      if (wr_valid_i) begin
        case (wr_field_i)
          3'd0: m_s  = from_bcd(wr_data_i);
          3'd1: m_mi = from_bcd(wr_data_i);
          3'd2: m_h  = from_bcd(wr_data_i);
          3'd3: m_wd = from_bcd(wr_data_i);
          3'd4: m_d  = from_bcd(wr_data_i);
          3'd5: m_mo = from_bcd(wr_data_i);
          3'd6: m_y  = from_bcd(wr_data_i);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk_i) begin
    if (cmp_on) begin
      chk("R2 seconds",   sec_o,   to_bcd(m_s));
      chk("R3 minutes",   min_o,   to_bcd(m_mi));
      chk("R3 hours",     hour_o,  to_bcd(m_h));
      chk("R3 weekday",   wday_o,  to_bcd(m_wd));
      chk("R4 day",       day_o,   to_bcd(m_d));
      chk("R4 month",     month_o, to_bcd(m_mo));
      chk("R4 year",      year_o,  to_bcd(m_y));
      chk("R2 half",      {7'd0, half_o}, 8'(m_half));
      chk("R9 sync",      {7'd0, sync_o},
          8'((m_half == 1 && m_sub >= HALF - LEAD) ? 1 : 0));
    end
  end

  task automatic run(input int n);
    en_i = 1'b1; tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic idle(input int n, input logic en, input logic tk);
    en_i = en; tick_i = tk;
    repeat (n) @(negedge clk_i);
    en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] f, input logic [7:0] d);
    wr_valid_i = 1'b1; wr_field_i = f; wr_data_i = d;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
    wr(3'd6, y); wr(3'd5, mo); wr(3'd4, d);
    wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
  endtask

  initial begin
    rst_ni = 1'b0; en_i = 1'b0; tick_i = 1'b0;
    wr_valid_i = 1'b0; wr_field_i = 3'd0; wr_data_i = 8'h00;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    cmp_on = 1'b1;

    // R1 reset state
    chk("R1 sec",   sec_o,   8'h00);
    chk("R1 hour",  hour_o,  8'h00);
    chk("R1 wday",  wday_o,  8'h06);
    chk("R1 day",   day_o,   8'h01);
    chk("R1 month", month_o, 8'h01);
    chk("R1 year",  year_o,  8'h00);
    chk("R1 flags", {6'd0, half_o, sync_o}, 8'h00);

    // R2 one second per TPS ticks
    run(7);
    chk("R2 before step sec", sec_o, 8'h00);
    chk("R2 second half", {7'd0, half_o}, 8'h01);
    run(1);
    chk("R2 step sec", sec_o, 8'h01);
    chk("R2 half cleared", {7'd0, half_o}, 8'h00);

    // R10 hold
    idle(12, 1'b0, 1'b1);
    chk("R10 en low sec", sec_o, 8'h01);
    idle(12, 1'b1, 1'b0);
    chk("R10 tick low sec", sec_o, 8'h01);
    chk("R10 tick low half", {7'd0, half_o}, 8'h00);

    // R6 write and R3 chain
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    chk("R6 write hour", hour_o, 8'h23);
    chk("R6 write sec", sec_o, 8'h59);
    run(8);
    chk("R3 sec wrap", sec_o, 8'h00);
    chk("R3 min wrap", min_o, 8'h00);
    chk("R3 hour wrap", hour_o, 8'h00);
    chk("R3 wday wrap", wday_o, 8'h00);
    chk("R3 day step", day_o, 8'h02);

    // R4 month lengths
    set_time(8'h21, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    run(8);
    chk("R4 april end day", day_o, 8'h01);
    chk("R4 april end month", month_o, 8'h05);
    set_time(8'h21, 8'h05, 8'h30, 8'h23, 8'h59, 8'h59);
    run(8);
    chk("R4 may day 31", day_o, 8'h31);
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    run(8);
    chk("R4 century year", year_o, 8'h00);
    chk("R4 century month", month_o, 8'h01);
    chk("R4 century day", day_o, 8'h01);

    // R5 leap year
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    run(8);
    chk("R5 leap feb 29", day_o, 8'h29);
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    run(8);
    chk("R5 leap mar 1 day", day_o, 8'h01);
    chk("R5 leap mar 1 month", month_o, 8'h03);
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    run(8);
    chk("R5 common mar 1", month_o, 8'h03);
    set_time(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    run(8);
    chk("R5 year 00 feb 29", day_o, 8'h29);

    // R7 seconds write realigns the second
    run(5);
    wr(3'd0, 8'h10);
    chk("R7 half cleared", {7'd0, half_o}, 8'h00);
    run(7);
    chk("R7 no early step", sec_o, 8'h10);
    run(1);
    chk("R7 step after full second", sec_o, 8'h11);

    // R8 write while counting, same cycle as a step
    run(7);
    en_i = 1'b1; tick_i = 1'b1;
    wr(3'd6, 8'h42);
    en_i = 1'b0; tick_i = 1'b0;
    chk("R8 sec still steps", sec_o, 8'h12);
    chk("R8 year written", year_o, 8'h42);
    wr(3'd7, 8'h33);
    chk("R6 code 7 ignored sec", sec_o, 8'h12);
    chk("R6 code 7 ignored year", year_o, 8'h42);

    // R9 sync window
    run(5);
    chk("R9 sync low early", {7'd0, sync_o}, 8'h00);
    run(1);
    chk("R9 sync high", {7'd0, sync_o}, 8'h01);
    run(2);
    chk("R9 sync low after step", {7'd0, sync_o}, 8'h00);
    chk("R9 step sec", sec_o, 8'h13);

    // mixed tick pattern against the reference
    set_time(8'h19, 8'h06, 8'h30, 8'h23, 8'h58, 8'h40);
    for (int i = 0; i < 600; i++) begin
      en_i = (i % 11 != 10); tick_i = (i % 3 != 0);
      @(negedge clk_i);
    end
    en_i = 1'b0; tick_i = 1'b0;
    @(negedge clk_i);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule